// File: doc/BRIEF.md
# Multi-Panel Write Address Sequencer

This block drives the buffer-loading order for a flash array that is divided into several equal panels, each with its own 8-byte write buffer. Once started, it visits every panel in turn and emits one buffer-load address per panel, all at the same 8-byte offset inside each panel. After the last panel's buffer has been filled, it issues one programming-start pulse, which commits all panel buffers together. It then waits out the combined write and discharge time, moves the offset forward by 8 bytes, and repeats from the first panel.

The caller supplies the panel count, the number of 8-byte slices per panel and a wait length in clock cycles. It may also signal early completion of the write through a dedicated input. These settings are captured when a run begins. The block reports a busy flag for the length of the run and a one-cycle done pulse when the run finishes. The serial transport that moves the data bytes, and the flash cells themselves, are outside this block.

Top module: `panel_wr_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `done`, `load_stb` and `prog_stb` are 0 and `addr` is 0. A reset in the middle of a run returns the block to idle.
- R2: A `start` sampled while idle, with nonzero panel and slice counts, makes `busy` and `load_stb` high in the next cycle with `addr` = 0.
- R3: Within one slice, `load_stb` is high on P consecutive cycles, where P is `num_panels`. The n-th strobe (n = 1..P) carries `addr` = (n-1)*0x2000 + 8*k, where k is the zero-based slice number.
- R4: In the cycle after the last buffer load of a slice, `prog_stb` is high for exactly one cycle. `prog_stb` and `load_stb` are never high together.
- R5: If the programming pulse appears in cycle t, the first load of the next slice (or `done` after the last slice) appears in cycle t+W, where W = `wait_cycles`. A value of 0 is treated as 1. In between, both strobes stay low and `busy` stays high.
- R6: When `prog_complete` is sampled high during a wait, the wait ends at that clock edge. The next load (or `done`) appears in the following cycle.
- R7: Every new slice restarts at the first panel, and its offset is 8 bytes above the offset of the previous slice.
- R8: After the wait that follows the S-th programming pulse (S = `num_slices`), `done` is high for exactly one cycle. `busy` is low in that same cycle, and no further strobes follow.
- R9: `start` is ignored while `busy` is high. Holding it high through a run does not alter the address sequence.
- R10: A `start` with `num_panels` = 0 or `num_slices` = 0 gives a single `done` pulse in the next cycle, with no strobes and `busy` kept low.
- R11: Panel count, slice count and wait length are captured at start. Changes to those inputs during a run have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled while idle) |
| num_panels | input | PANEL_W | Number of panels to visit per slice |
| num_slices | input | SLICE_W | Number of 8-byte slices per panel |
| wait_cycles | input | WAIT_W | Write plus discharge time in cycles |
| prog_complete | input | 1 | Early end of the current wait |
| addr | output | ADDR_W | Buffer-load address, valid with `load_stb` |
| load_stb | output | 1 | One 8-byte buffer load at `addr` |
| prog_stb | output | 1 | Start programming all loaded buffers |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest situation to reach from the ports is the interaction of timing sources during a wait. An early completion must cut the timer short on one slice, while the following slices must still honour the full cycle count. Input changes during a run must also be shown to be ignored. To reach these cases, the stimulus pulses `prog_complete` at a chosen offset inside the first wait only. On a separate run, it holds `start` high and swaps all three configuration inputs to different values right after the run begins, while the cycle-exact expected strobe pattern is still computed from the original values.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_WAIT = 2'd2
  } pws_state_e;
endpackage

// File: rtl/pws_addr_gen.sv
module pws_addr_gen #(
  parameter int ADDR_W     = 22,
  parameter int PANEL_W    = 4,
  parameter int SLICE_W    = 10,
  parameter int PANEL_SPAN = 32'h2000,
  parameter int LOAD_BYTES = 8
) (
  input  logic [PANEL_W-1:0] panel_idx,
  input  logic [SLICE_W-1:0] slice_idx,
  output logic [ADDR_W-1:0]  addr
);
  localparam int  SPAN_SH  = $clog2(PANEL_SPAN);
  localparam int  LOAD_SH  = $clog2(LOAD_BYTES);
  localparam bit  SPAN_POW = ((PANEL_SPAN & (PANEL_SPAN - 1)) == 0);

  logic [ADDR_W-1:0] offs;
  assign offs = ADDR_W'(slice_idx) << LOAD_SH;

  generate
    if (SPAN_POW) begin : g_shift
      assign addr = (ADDR_W'(panel_idx) << SPAN_SH) + offs;
    end else begin : g_mult
      assign addr = ADDR_W'(panel_idx) * ADDR_W'(PANEL_SPAN) + offs;
    end
  endgenerate
endmodule

// File: rtl/pws_wait_timer.sv
module pws_wait_timer #(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              run,
  input  logic [WAIT_W-1:0] limit,
  input  logic              early,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt;
  logic [WAIT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign expired = run && ((cnt_inc >= {1'b0, limit}) || early);

  always_ff @(posedge clk) begin
    if (rst || arm)          cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end

  // R5: the running count never passes the programmed limit
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (({1'b0, cnt} < {1'b0, limit}) || (cnt == '0)));
endmodule

// File: rtl/panel_wr_seq.sv
module panel_wr_seq
  import pws_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int PANEL_W    = 4,
  parameter int SLICE_W    = 10,
  parameter int WAIT_W     = 16,
  parameter int PANEL_SPAN = 32'h2000,
  parameter int LOAD_BYTES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [PANEL_W-1:0] num_panels,
  input  logic [SLICE_W-1:0] num_slices,
  input  logic [WAIT_W-1:0]  wait_cycles,
  input  logic               prog_complete,
  output logic [ADDR_W-1:0]  addr,
  output logic               load_stb,
  output logic               prog_stb,
  output logic               busy,
  output logic               done
);
  pws_state_e st, st_n;

  logic [PANEL_W-1:0] pan, pan_n, npan_q;
  logic [SLICE_W-1:0] slc, slc_n, nslc_q;
  logic [WAIT_W-1:0]  wait_q;
  logic               ld_n, pg_n, dn_n, bz_n, arm, expired;
  logic [ADDR_W-1:0]  gen_addr;
  logic [PANEL_W:0]   pan_inc;
  logic [SLICE_W:0]   slc_inc;

  assign pan_inc = {1'b0, pan} + 1'b1;
  assign slc_inc = {1'b0, slc} + 1'b1;

  pws_addr_gen #(
    .ADDR_W(ADDR_W), .PANEL_W(PANEL_W), .SLICE_W(SLICE_W),
    .PANEL_SPAN(PANEL_SPAN), .LOAD_BYTES(LOAD_BYTES)
  ) u_addr (
    .panel_idx(pan_n),
    .slice_idx(slc_n),
    .addr     (gen_addr)
  );

  pws_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .arm    (arm),
    .run    (st == ST_WAIT),
    .limit  (wait_q),
    .early  (prog_complete),
    .expired(expired)
  );

  always_comb begin
    st_n  = st;
    pan_n = pan;
    slc_n = slc;
    ld_n  = 1'b0;
    pg_n  = 1'b0;
    dn_n  = 1'b0;
    bz_n  = busy;
    arm   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          if (num_panels == '0 || num_slices == '0) begin
            dn_n = 1'b1;
          end else begin
            st_n  = ST_LOAD;
            pan_n = '0;
            slc_n = '0;
            ld_n  = 1'b1;
            bz_n  = 1'b1;
          end
        end
      end
      ST_LOAD: begin
        if (pan_inc < {1'b0, npan_q}) begin
          pan_n = pan + 1'b1;
          ld_n  = 1'b1;
        end else begin
          pg_n = 1'b1;
          arm  = 1'b1;
          st_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (expired) begin
          if (slc_inc == {1'b0, nslc_q}) begin
            st_n = ST_IDLE;
            dn_n = 1'b1;
            bz_n = 1'b0;
          end else begin
            slc_n = slc + 1'b1;
            pan_n = '0;
            ld_n  = 1'b1;
            st_n  = ST_LOAD;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      pan      <= '0;
      slc      <= '0;
      npan_q   <= '0;
      nslc_q   <= '0;
      wait_q   <= '0;
      addr     <= '0;
      load_stb <= 1'b0;
      prog_stb <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      st       <= st_n;
      pan      <= pan_n;
      slc      <= slc_n;
      load_stb <= ld_n;
      prog_stb <= pg_n;
      busy     <= bz_n;
      done     <= dn_n;
      if (ld_n) addr <= gen_addr;
      if (st == ST_IDLE && start) begin
        npan_q <= num_panels;
        nslc_q <= num_slices;
        wait_q <= wait_cycles;
      end
    end
  end

  // R4: strobes exclusive, programming pulse lasts one cycle
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(load_stb && prog_stb));
  a_r4_prog_single: assert property (@(posedge clk) disable iff (rst)
    prog_stb |=> !prog_stb);
  // R3: back-to-back loads step by one panel span
  a_r3_panel_step: assert property (@(posedge clk) disable iff (rst)
    (load_stb && $past(load_stb)) |-> (addr == $past(addr) + ADDR_W'(PANEL_SPAN)));
  // R8: done is a single pulse with busy low
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R2: a run opens with a load at address zero
  a_r2_first_load: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (load_stb && addr == '0));
  // R4: programming only inside a run
  a_r4_prog_busy: assert property (@(posedge clk) disable iff (rst)
    prog_stb |-> busy);
endmodule

// File: tb/tb_panel_wr_seq.sv
module tb_panel_wr_seq;
  localparam int ADDR_W  = 22;
  localparam int PANEL_W = 4;
  localparam int SLICE_W = 10;
  localparam int WAIT_W  = 16;
  localparam int SPAN    = 32'h2000;

  // vector: panels, slices, wait, early-complete offset (-1 = none)
  localparam int NVEC = 6;
  localparam int VEC[NVEC][4] = '{
    '{1, 1, 1, -1},
    '{2, 3, 4, -1},
    '{4, 2, 0, -1},
    '{3, 2, 5,  1},
    '{15, 1, 2, -1},
    '{1, 4, 3,  0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [PANEL_W-1:0] num_panels = '0;
  logic [SLICE_W-1:0] num_slices = '0;
  logic [WAIT_W-1:0]  wait_cycles = '0;
  logic prog_complete = 1'b0;
  logic [ADDR_W-1:0] addr;
  logic load_stb, prog_stb, busy, done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  panel_wr_seq dut (
    .clk(clk), .rst(rst), .start(start),
    .num_panels(num_panels), .num_slices(num_slices),
    .wait_cycles(wait_cycles), .prog_complete(prog_complete),
    .addr(addr), .load_stb(load_stb), .prog_stb(prog_stb),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(!busy && !load_stb && !prog_stb && !done, req,
        {busy, load_stb, prog_stb, done}, 32'h0);
  endtask

  task automatic run_case(input int p, input int s, input int w, input int early,
                          input bit noisy);
    int weff;
    int e;
    weff = (w == 0) ? 1 : w;
    @(negedge clk);
    num_panels  = PANEL_W'(p);
    num_slices  = SLICE_W'(s);
    wait_cycles = WAIT_W'(w);
    start = 1'b1;
    @(negedge clk);
    if (noisy) begin
      // R11 / R9: alter inputs and keep start high during the run
      num_panels  = PANEL_W'(p + 3);
      num_slices  = SLICE_W'(s + 2);
      wait_cycles = WAIT_W'(w + 7);
    end else begin
      start = 1'b0;
    end
    chk(busy, "R2", busy, 1);
    for (int l = 0; l < s; l++) begin
      for (int n = 0; n < p; n++) begin
        logic [31:0] ea;
        ea = 32'((n * SPAN) + (8 * l));
        chk(load_stb && !prog_stb && busy && addr == ea[ADDR_W-1:0],
            (l > 0 && n == 0) ? "R7" : "R3", {load_stb, 9'd0, addr}, {1'b1, 9'd0, ea[ADDR_W-1:0]});
        @(negedge clk);
      end
      chk(prog_stb && !load_stb, "R4", {prog_stb, load_stb}, 2'b10);
      e = (early >= 0 && l == 0) ? early + 1 : weff;
      for (int j = 0; j < e; j++) begin
        prog_complete = (l == 0 && j == early);
        if (j > 0)
          chk(!load_stb && !prog_stb && busy && !done, (early >= 0 && l == 0) ? "R6" : "R5",
              {load_stb, prog_stb, busy, done}, 4'b0010);
        @(negedge clk);
      end
      prog_complete = 1'b0;
    end
    chk(done && !busy && !load_stb && !prog_stb, "R8",
        {done, busy, load_stb, prog_stb}, 4'b1000);
    start = 1'b0;
    num_panels  = PANEL_W'(p);
    num_slices  = SLICE_W'(s);
    wait_cycles = WAIT_W'(w);
    @(negedge clk);
    chk_idle("R8");
  endtask

  task automatic zero_case(input int p, input int s);
    @(negedge clk);
    num_panels = PANEL_W'(p);
    num_slices = SLICE_W'(s);
    wait_cycles = WAIT_W'(2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !busy && !load_stb && !prog_stb, "R10",
        {done, busy, load_stb, prog_stb}, 4'b1000);
    @(negedge clk);
    chk_idle("R10");
    @(negedge clk);
    chk_idle("R10");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk_idle("R1");
    chk(addr == '0, "R1", addr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1");

    // vector table walk
    for (int v = 0; v < NVEC; v++)
      run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);

    // R9 / R11: start held and inputs changed during the run
    run_case(2, 2, 3, -1, 1'b1);

    // R10: degenerate counts
    zero_case(0, 3);
    zero_case(3, 0);

    // R1: reset in the middle of a run
    @(negedge clk);
    num_panels = 4'd3; num_slices = 10'd5; wait_cycles = 16'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_idle("R1");
    chk(addr == '0, "R1", addr, 0);
    repeat (12) begin
      @(negedge clk);
      chk_idle("R1");
    end

    // run again after the aborted one
    run_case(2, 1, 1, -1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule